// File: doc/BRIEF.md
# Dual Independent 32-bit Interval Timer

This block is a register-mapped timer with two separate 32-bit up-counters, a low half and a high half. Each half has its own period register and a two-bit run mode: stopped, single pass, or continuous. A global control register sets the timer mode and holds each half in reset or releases it. Software can read either counter at any time and can overwrite it directly, so a half set to continuous with a period of all ones serves as a free-running wrapping time base. The other half can deliver interval interrupts.

When a running half's count equals its period, the count returns to zero and the half raises a one-cycle interrupt pulse. A single-pass half then clears its own run-mode field and stops. The low half also has a compare register. When the low counter advances to the compare value, an event pulse is raised. This lets software schedule an event at "now plus delta" without stopping the counter. The compare event and the low period event share the low interrupt output. The high half drives its own interrupt output.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads 0, both halves are held in reset with run mode 00, and both interrupt outputs are low.
- R2: Registers sit at these byte addresses: 0x10 low counter, 0x14 high counter, 0x18 low period, 0x1C high period, 0x20 run-control word, 0x24 global control, 0x28 low compare. In the run-control word only bits 7:6 (low mode) and 23:22 (high mode) are stored. In global control only bits 3:0 are stored. All other bits and all other addresses read 0.
- R3: A half counts up by one per clock when all three of these hold: its mode field is 01 or 10, its release bit is 1, and the timer mode is 01. Counting starts on the first clock after the mode write. Mode 00 (and the reserved value 11) freeze the count.
- R4: When a running half's count equals its period, the next clock sets the count to 0 and raises that half's interrupt for exactly that one cycle. With period P, continuous mode interrupts every P+1 clocks.
- R5: In single-pass mode (01), the period match also clears the half's mode field to 00, and the counter then holds at 0.
- R6: Global control bit 0 releases the low half and bit 1 releases the high half. A half whose bit is 0 holds its counter at 0 and ignores counter writes. A timer mode field (bits 3:2) other than 01 stops both halves.
- R7: With period 0xFFFFFFFF in continuous mode, the counter passes 0xFFFFFFFF and wraps to 0, raising the interrupt at the wrap.
- R8: When the running low counter advances to the value in the compare register, a one-cycle pulse appears on the low interrupt output on the next cycle. This pulse is ORed with the low period interrupt.
- R9: The high half counts and interrupts on its own output, regardless of the low half's mode and events. The low half is likewise unaffected by the high half.
- R10: A software counter write takes priority over counting in the same clock. A software run-control write takes priority over the single-pass self-clear in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of register access |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_lo_o | output | 1 | Low half period-match or compare-match pulse |
| irq_hi_o | output | 1 | High half period-match pulse |

## Verification
The hardest case to reach is a software write that lands on the same clock edge as a hardware event. One example is a single-pass half matching its period while its mode field is being rewritten. Another is a counter write colliding with an increment. The bench counts clock edges from the write that starts a half, so it knows the exact edge of the match. It then issues the colliding write on that edge and checks the result at the ports. The wrap at 0xFFFFFFFF is reached by preloading the counter a few counts below it instead of waiting 2^32 clocks.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONE  = 2'b01,
    MODE_CONT = 2'b10,
    MODE_RSV  = 2'b11
  } run_mode_e;

  localparam int OFS_CNT  = 'h10;  // +4 per half
  localparam int OFS_PRD  = 'h18;  // +4 per half
  localparam int OFS_RUN  = 'h20;
  localparam int OFS_GLB  = 'h24;
  localparam int OFS_CMP  = 'h28;

  localparam int LO_MODE_LSB  = 6;
  localparam int HI_MODE_LSB  = 22;
  localparam int GMODE_LSB    = 2;
  localparam logic [1:0] GMODE_SPLIT = 2'b01;
  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/dtim_half.sv
module dtim_half
  import dtim_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rel_i,
  input  logic             glob_run_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cnt_we_i,
  input  logic             prd_we_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] prd_o,
  output logic [1:0]       mode_o,
  output logic             adv_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, prd_q, nxt;
  run_mode_e        mode_q;
  logic             tick_q, run, at_prd;

  assign run    = rel_i && glob_run_i && (mode_q == MODE_ONE || mode_q == MODE_CONT);
  assign at_prd = (cnt_q == prd_q);
  assign nxt    = at_prd ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!rel_i) begin
      cnt_q <= '0;
    end else if (cnt_we_i) begin
      cnt_q <= wdata_i;
    end else if (run) begin
      cnt_q <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prd_q <= '0;
    else if (prd_we_i) prd_q <= wdata_i;
  end

  // software write beats the single-pass self-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
    end else if (mode_we_i) begin
      mode_q <= run_mode_e'(mode_wdata_i);
    end else if (run && at_prd && mode_q == MODE_ONE) begin
      mode_q <= MODE_OFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= run && at_prd;
  end

  assign cnt_o  = cnt_q;
  assign prd_o  = prd_q;
  assign mode_o = mode_q;
  assign adv_o  = rel_i && !cnt_we_i && run;
  assign nxt_o  = nxt;
  assign tick_o = tick_q;

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !at_prd && !cnt_we_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !run && !cnt_we_i) |=> $stable(cnt_q));

  p_wrap_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && !$past(cnt_we_i)) |-> (cnt_q == '0));

  p_oneshot_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && at_prd && mode_q == MODE_ONE && !mode_we_i) |=> (mode_q == MODE_OFF));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_i |=> (cnt_q == '0));
endmodule

// File: rtl/dtim_cmp.sv
module dtim_cmp #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= wdata_i;
  end

  // event when the counter steps onto the compare value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= adv_i && (nxt_i == cmp_q);
  end

  assign cmp_o = cmp_q;
  assign hit_o = hit_q;

  p_hit_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> $past(adv_i));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtim_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int DATA_W = 32;
  localparam int GLB_W  = GMODE_LSB + 2;
  localparam logic [ADDR_W-1:0] A_RUN = ADDR_W'(OFS_RUN);
  localparam logic [ADDR_W-1:0] A_GLB = ADDR_W'(OFS_GLB);
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFS_CMP);

  logic [GLB_W-1:0] glb_q;
  logic             glob_run;
  logic [CNT_W-1:0] cnt  [NUM_HALVES];
  logic [CNT_W-1:0] prd  [NUM_HALVES];
  logic [CNT_W-1:0] nxt  [NUM_HALVES];
  logic [1:0]       mode [NUM_HALVES];
  logic             adv  [NUM_HALVES];
  logic             tick [NUM_HALVES];
  logic [CNT_W-1:0] cmp_val;
  logic             cmp_hit;
  logic             run_we;

  assign glob_run = (glb_q[GMODE_LSB +: 2] == GMODE_SPLIT);
  assign run_we   = wr_en_i && (addr_i == A_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           glb_q <= '0;
    else if (wr_en_i && addr_i == A_GLB)   glb_q <= wdata_i[GLB_W-1:0];
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam int MLSB = (h == 0) ? LO_MODE_LSB : HI_MODE_LSB;
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT + 4 * h);
    localparam logic [ADDR_W-1:0] A_PRD = ADDR_W'(OFS_PRD + 4 * h);

    dtim_half #(.CNT_W(CNT_W)) u_half (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .rel_i        (glb_q[h]),
      .glob_run_i   (glob_run),
      .wdata_i      (wdata_i[CNT_W-1:0]),
      .cnt_we_i     (wr_en_i && addr_i == A_CNT),
      .prd_we_i     (wr_en_i && addr_i == A_PRD),
      .mode_we_i    (run_we),
      .mode_wdata_i (wdata_i[MLSB +: 2]),
      .cnt_o        (cnt[h]),
      .prd_o        (prd[h]),
      .mode_o       (mode[h]),
      .adv_o        (adv[h]),
      .nxt_o        (nxt[h]),
      .tick_o       (tick[h])
    );
  end

  dtim_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_we_i (wr_en_i && addr_i == A_CMP),
    .wdata_i  (wdata_i[CNT_W-1:0]),
    .adv_i    (adv[0]),
    .nxt_i    (nxt[0]),
    .cmp_o    (cmp_val),
    .hit_o    (cmp_hit)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_CNT):     rdata_o = DATA_W'(cnt[0]);
      ADDR_W'(OFS_CNT + 4): rdata_o = DATA_W'(cnt[1]);
      ADDR_W'(OFS_PRD):     rdata_o = DATA_W'(prd[0]);
      ADDR_W'(OFS_PRD + 4): rdata_o = DATA_W'(prd[1]);
      A_RUN: begin
        rdata_o[LO_MODE_LSB +: 2] = mode[0];
        rdata_o[HI_MODE_LSB +: 2] = mode[1];
      end
      A_GLB:   rdata_o = DATA_W'(glb_q);
      A_CMP:   rdata_o = DATA_W'(cmp_val);
      default: rdata_o = '0;
    endcase
  end

  assign irq_lo_o = tick[0] | cmp_hit;
  assign irq_hi_o = tick[1];

  p_hi_rel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> $past(glb_q[1]));
endmodule

// File: tb/dual_timer_test.sv
module dual_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq_lo, irq_hi;
  int            checks = 0;
  int            fails = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_timer #(.CNT_W(32), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 64; a += 4) begin
      rd(AW'(a), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq_lo", {31'b0, irq_lo}, 32'h0);
    chk("R1 irq_hi", {31'b0, irq_hi}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr('h18, 32'hA5A5_0001); wr('h1C, 32'h5A5A_0002);
    wr('h28, 32'h1234_5678); wr('h20, 32'hFFFF_FFFF); wr('h24, 32'hFFFF_FFFF);
    rd('h18, v); chk("R2 low period", v, 32'hA5A5_0001);
    rd('h1C, v); chk("R2 high period", v, 32'h5A5A_0002);
    rd('h28, v); chk("R2 compare", v, 32'h1234_5678);
    rd('h20, v); chk("R2 run-control fields", v, 32'h00C0_00C0);
    rd('h24, v); chk("R2 global bits", v, 32'h0000_000F);
    rd('h2C, v); chk("R2 undefined 0x2C", v, 32'h0);
    rd('h00, v); chk("R2 undefined 0x00", v, 32'h0);
    wr('h20, 32'h0);
    wr('h24, 32'h7);
  endtask

  task automatic t_count();
    logic [31:0] v, x;
    wr('h18, 32'd100);
    wr('h10, 32'd5);
    wr('h20, 32'h80);
    repeat (3) edge1();
    rd('h10, v); chk("R3 count 3 clocks", v, 32'd8);
    wr('h20, 32'h0);
    rd('h10, x);
    repeat (4) edge1();
    rd('h10, v); chk("R3 frozen", v, x);
  endtask

  task automatic t_period();
    wr('h10, 32'd0); wr('h18, 32'd3);
    wr('h20, 32'h80);
    for (int k = 1; k <= 8; k++) begin
      edge1();
      chk("R4 period irq", {31'b0, irq_lo}, {31'b0, (k % 4) == 0});
      chk("R9 high quiet", {31'b0, irq_hi}, 32'h0);
    end
    wr('h20, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr('h10, 32'd0); wr('h18, 32'd2);
    wr('h20, 32'h40);
    for (int k = 1; k <= 3; k++) begin
      edge1();
      chk("R5 oneshot irq", {31'b0, irq_lo}, {31'b0, k == 3});
    end
    rd('h20, v); chk("R5 mode cleared", v, 32'h0);
    for (int k = 0; k < 3; k++) begin
      edge1();
      chk("R5 no repeat irq", {31'b0, irq_lo}, 32'h0);
    end
    rd('h10, v); chk("R5 holds at 0", v, 32'h0);
  endtask

  task automatic t_high();
    wr('h14, 32'd0); wr('h1C, 32'd1);
    wr('h20, 32'h0080_0000);
    for (int k = 1; k <= 4; k++) begin
      edge1();
      chk("R9 high irq", {31'b0, irq_hi}, {31'b0, (k % 2) == 0});
      chk("R9 low quiet", {31'b0, irq_lo}, 32'h0);
    end
    wr('h20, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    logic [31:0] exp_c [4] = '{32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0, 32'h1};
    wr('h18, 32'hFFFF_FFFF); wr('h10, 32'hFFFF_FFFD);
    wr('h20, 32'h80);
    for (int k = 1; k <= 4; k++) begin
      edge1();
      chk("R7 wrap irq", {31'b0, irq_lo}, {31'b0, k == 3});
      rd('h10, v); chk("R7 wrap count", v, exp_c[k-1]);
    end
    wr('h20, 32'h0);
  endtask

  task automatic t_compare();
    wr('h18, 32'hFFFF_FFFF); wr('h10, 32'd10); wr('h28, 32'd15);
    wr('h20, 32'h80);
    for (int k = 1; k <= 8; k++) begin
      edge1();
      chk("R8 compare irq", {31'b0, irq_lo}, {31'b0, k == 5});
      chk("R8 high separate", {31'b0, irq_hi}, 32'h0);
    end
    wr('h20, 32'h0);
    wr('h28, 32'hFFFF_0000);
  endtask

  task automatic t_global();
    logic [31:0] v;
    wr('h24, 32'h6);
    wr('h10, 32'd7);
    rd('h10, v); chk("R6 held write ignored", v, 32'h0);
    wr('h20, 32'h80);
    repeat (3) edge1();
    rd('h10, v); chk("R6 held no count", v, 32'h0);
    wr('h24, 32'hB);
    wr('h10, 32'd20);
    repeat (3) edge1();
    rd('h10, v); chk("R6 bad timer mode stops", v, 32'd20);
    wr('h24, 32'h7);
    edge1();
    rd('h10, v); chk("R6 resumes", v, 32'd21);
    wr('h20, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr('h18, 32'hFFFF_FFFF);
    wr('h20, 32'h80);
    repeat (2) edge1();
    wr('h10, 32'd50);
    rd('h10, v); chk("R10 write beats count", v, 32'd50);
    edge1();
    rd('h10, v); chk("R10 counts after write", v, 32'd51);
    wr('h20, 32'h0);
    wr('h10, 32'd0); wr('h18, 32'd2);
    wr('h20, 32'h40);
    repeat (2) @(posedge clk);
    wr('h20, 32'h40);
    rd('h20, v); chk("R10 mode write beats self-clear", v, 32'h40);
    rd('h10, v); chk("R10 match still wraps", v, 32'h0);
    edge1();
    rd('h10, v); chk("R10 single pass rearmed", v, 32'd1);
    wr('h20, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_count();
    t_period();
    t_oneshot();
    t_high();
    t_wrap();
    t_compare();
    t_global();
    t_priority();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule